// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM of 256K locations. The host hands it one request at a time: a read or a write with an 18-bit address and, for writes, one data byte. The controller then plays out the strobe sequence on the memory pins, holds every phase for a whole number of clock cycles, and returns read data to the host as a single-cycle pulse.

Each minimum memory timing, given in nanoseconds for a fast and a slow speed grade, is turned into a cycle count when the block is elaborated. The count is the timing divided by the clock period parameter, rounded up, and never less than one. A write runs through four phases. First the chip is selected with the data drivers on. Next the write strobe is held low. Then the write strobe rises while the chip stays selected and the data stays driven. Last comes a recovery gap. A read holds chip select and output enable low together for the access count and samples the bus on the final cycle of it. The shared data bus appears as separate out, in and drive-enable signals.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0, req_ready is 1 and rd_valid is 0.
- R2: A read holds sram_ce_n and sram_oe_n low with sram_we_n high for exactly ACC cycles. ACC is the larger of the address-access count and the output-enable count. rd_valid pulses for one cycle, ACC cycles after the accepting edge, and carries the byte present on sram_dq_in during the last cycle of that window.
- R3: A write holds sram_ce_n low for WP+2 cycles and keeps sram_oe_n high the whole time. sram_we_n is low for exactly WP cycles, where WP is the larger of the write-pulse count and the data-setup count. sram_we_n rises one cycle before sram_ce_n, and sram_dq_oe stays 1 until sram_ce_n rises.
- R4: While sram_ce_n is low, sram_addr is constant and equal to the accepted req_addr.
- R5: sram_dq_oe is never 1 while sram_oe_n is 0. sram_dq_oe is already 1 in the cycle before sram_we_n falls.
- R6: Every count equals ceil(t_ns / CLK_PERIOD_NS) with a minimum of 1. SPEED_GRADE=0 selects the fast timings (access 70, OE access 35, read cycle 70, write cycle 70, pulse 55, setup 30, recovery 5 ns). SPEED_GRADE=1 selects the slow timings (100, 50, 100, 100, 75, 40, 5 ns).
- R7: Between two cycles, sram_ce_n stays high for at least REC+1 cycles. After a read, REC is max(1, read-cycle count − ACC). After a write, REC is max(1, recovery count, write-cycle count − WP − 2).
- R8: A request is taken only on an edge where req_valid and req_ready are both 1. req_ready is 0 from acceptance until the cycle is complete. A request presented while req_ready is 0 has no effect.
- R9: Reading an address returns the byte most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 18 | Memory address pins |
| sram_dq_out | output | 8 | Data driven onto the bus |
| sram_dq_in | input | 8 | Data read from the bus |
| sram_dq_oe | output | 1 | Controller drives the bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach from the ports is a read that samples the bus one cycle too early. A memory that returns data instantly would hide that fault. The bench memory model therefore returns valid data only once chip select and output enable have been low together for ACC cycles, and it returns the inverse of the stored byte before then. A further test presents a write while a read is in progress, removes it before req_ready returns, and then reads the target address back. That read-back shows the stray write never reached the memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REC,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_REC
    } seq_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = cap;
        if (cap) cap_d.dat = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_valid = cap_q.vld;
    assign rd_data  = cap_q.dat;

    assert_rdvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int ACC_CYC   = 9,
    parameter int RREC_CYC  = 1,
    parameter int WP_CYC    = 7,
    parameter int WREC_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdat,
    output logic              drv,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n
);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] RREC_LD = CNT_W'(RREC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WREC_LD = CNT_W'(WREC_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    seq_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_write) begin
                        seq_d.st   = ST_WR_SET;
                        seq_d.wdat = req_wdata;
                        seq_d.drv  = 1'b1;
                        tmr_val    = '0;
                    end else begin
                        seq_d.st   = ST_RD_ACC;
                        seq_d.oe_n = 1'b0;
                        tmr_val    = ACC_LD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    cap        = 1'b1;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    seq_d.st   = ST_RD_REC;
                    tmr_load   = 1'b1;
                    tmr_val    = RREC_LD;
                end
            end
            ST_RD_REC: begin
                if (tmr_done) seq_d.st = ST_IDLE;
            end
            ST_WR_SET: begin
                if (tmr_done) begin
                    seq_d.we_n = 1'b0;
                    seq_d.st   = ST_WR_PULSE;
                    tmr_load   = 1'b1;
                    tmr_val    = WP_LD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    seq_d.we_n = 1'b1;
                    seq_d.st   = ST_WR_HOLD;
                    tmr_load   = 1'b1;
                    tmr_val    = '0;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    seq_d.ce_n = 1'b1;
                    seq_d.drv  = 1'b0;
                    seq_d.st   = ST_WR_REC;
                    tmr_load   = 1'b1;
                    tmr_val    = WREC_LD;
                end
            end
            ST_WR_REC: begin
                if (tmr_done) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.ce_n <= 1'b1;
            seq_q.we_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign addr      = seq_q.addr;
    assign wdat      = seq_q.wdat;
    assign drv       = seq_q.drv;
    assign ce_n      = seq_q.ce_n;
    assign we_n      = seq_q.we_n;
    assign oe_n      = seq_q.oe_n;

    assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !drv);
    assert_drv_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(drv));
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !req_ready);
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    localparam bit SLOW = (SPEED_GRADE != 0);
    localparam int T_ACC_NS = SLOW ? 100 : 70;
    localparam int T_OE_NS  = SLOW ? 50  : 35;
    localparam int T_RC_NS  = SLOW ? 100 : 70;
    localparam int T_WC_NS  = SLOW ? 100 : 70;
    localparam int T_WP_NS  = SLOW ? 75  : 55;
    localparam int T_DS_NS  = SLOW ? 40  : 30;
    localparam int T_WR_NS  = 5;

    localparam int ACC_CYC  = max2(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
    localparam int WR_CYC   = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int RREC_CYC = max2(1, RC_CYC - ACC_CYC);
    localparam int WREC_CYC = max2(max2(1, WR_CYC), WC_CYC - WP_CYC - 2);
    localparam int MAX_CYC  = max2(max2(ACC_CYC, WP_CYC), max2(RREC_CYC, WREC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap;

    sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .ACC_CYC  (ACC_CYC),
        .RREC_CYC (RREC_CYC),
        .WP_CYC   (WP_CYC),
        .WREC_CYC (WREC_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cap       (cap),
        .addr      (sram_addr),
        .wdat      (sram_dq_out),
        .drv       (sram_dq_oe),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .bus_in   (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assert_capture_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!sram_oe_n) && $past(!sram_ce_n) && $past(sram_we_n)));
endmodule

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
    localparam int PER = 8;

    function automatic int cdiv(input int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // fast grade expectations
    localparam int E_ACC  = mx(cdiv(70), cdiv(35));
    localparam int E_WP   = mx(cdiv(55), cdiv(30));
    localparam int E_RREC = mx(1, cdiv(70) - E_ACC);
    localparam int E_WREC = mx(mx(1, cdiv(5)), cdiv(70) - E_WP - 2);

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid, sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;
    logic [7:0]  rd_data, sram_dq_out;
    logic [7:0]  sram_dq_in = 8'h00;
    logic [17:0] sram_addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sram_bus_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(0)) i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // memory model indexed by the low address byte; bench keeps those unique
    logic [7:0] mem [256];
    logic [17:0] exp_addr = '0;
    int  strobe_cnt = 0, lo_cnt = 0, hi_cnt = 0, we_cnt = 0;
    bit  prev_ce_n = 1, prev_we_n = 1, cur_rd = 0, last_rd = 0, started = 0, drv_ok = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ce_n && !sram_ce_n) begin
                cur_rd = !sram_oe_n;
                chk(sram_addr == exp_addr, "R4", int'(sram_addr), int'(exp_addr));
                if (started)
                    chk(hi_cnt >= (last_rd ? E_RREC : E_WREC) + 1, "R7", hi_cnt,
                        (last_rd ? E_RREC : E_WREC) + 1);
                started = 1;
                lo_cnt = 0;
            end
            if (!sram_ce_n) begin
                lo_cnt++;
                hi_cnt = 0;
                if (sram_addr != exp_addr)
                    chk(0, "R4", int'(sram_addr), int'(exp_addr));
                if (!cur_rd && !sram_oe_n) chk(0, "R3", 0, 1);
            end else begin
                hi_cnt++;
            end
            if (!prev_ce_n && sram_ce_n) begin
                chk(lo_cnt == (cur_rd ? E_ACC : E_WP + 2), cur_rd ? "R2" : "R3",
                    lo_cnt, cur_rd ? E_ACC : E_WP + 2);
                last_rd = cur_rd;
            end
            if (!sram_oe_n && sram_dq_oe) chk(0, "R5", 1, 0);
            if (prev_we_n && !sram_we_n) begin
                we_cnt = 0;
                drv_ok = 1;
            end
            if (!sram_we_n) begin
                we_cnt++;
                if (!sram_dq_oe) drv_ok = 0;
            end
            if (!prev_we_n && sram_we_n) begin
                chk(we_cnt == E_WP, "R3", we_cnt, E_WP);
                chk(drv_ok && sram_dq_oe && !sram_ce_n, "R3", int'(sram_dq_oe), 1);
                mem[sram_addr[7:0]] = sram_dq_out;
            end
            if (!sram_ce_n && !sram_oe_n && sram_we_n) strobe_cnt++;
            else strobe_cnt = 0;
            sram_dq_in = (strobe_cnt >= E_ACC) ? mem[sram_addr[7:0]] : ~mem[sram_addr[7:0]];
            prev_ce_n = sram_ce_n;
            prev_we_n = sram_we_n;
        end
    end

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; exp_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] e, input string req);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; exp_addr = a;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        req_valid = 0;
        while (!rd_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == E_ACC, "R2", n, E_ACC);
        chk(rd_data == e, req, int'(rd_data), int'(e));
        @(negedge clk);
        chk(!rd_valid, "R2", int'(rd_valid), 0);
    endtask

    function automatic logic [17:0] addr_of(input int i);
        return {i[1:0], i[7:0] ^ 8'hA5, i[7:0]};
    endfunction
    function automatic logic [7:0] data_of(input int i, input int s);
        return 8'((i * 37 + s * 11 + 3) & 8'hFF);
    endfunction

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
        chk(!sram_dq_oe && req_ready && !rd_valid, "R1", int'({sram_dq_oe, req_ready, rd_valid}), 2);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(req_ready, "R1", int'(req_ready), 1);

        // R9 / R6 sweep over every low address byte, two data patterns
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 256; i++) do_write(addr_of(i), data_of(i, s));
            for (int i = 0; i < 256; i++) do_read(addr_of(i), data_of(i, s), "R9");
        end

        // corner addresses
        do_write(18'h3FFFF, 8'h5A);
        do_read(18'h3FFFF, 8'h5A, "R9");
        do_write(18'h00000, 8'hC3);
        do_read(18'h00000, 8'hC3, "R9");

        // R8: request offered while busy is ignored
        do_write(addr_of(17), 8'h11);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = addr_of(17); exp_addr = addr_of(17);
        @(posedge clk);
        @(negedge clk);
        chk(!req_ready, "R8", int'(req_ready), 0);
        req_valid = 1; req_write = 1; req_addr = addr_of(42); req_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        chk(!req_ready, "R8", int'(req_ready), 0);
        req_valid = 0; req_write = 0; req_addr = addr_of(17);
        while (!rd_valid) @(negedge clk);
        chk(rd_data == 8'h11, "R8", int'(rd_data), 8'h11);
        do_read(addr_of(42), data_of(42, 1), "R8");

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule